// File: doc/BRIEF.md
# Super-I/O Indexed Configuration Port

This block is the configuration front end of a multi-function I/O controller. The host reaches it through two byte-wide ports, an index port and a data port, selected by `port_sel_i`. After a two-write unlock sequence on the index port, the host writes a register number to the index port. It then reads or writes that register through the data port. Writing the lock byte to the index port closes configuration access again.

One global register chooses which logical device's bank of registers the data port reaches. Each bank holds an enable bit, a 16-bit I/O base address and an IRQ number. The bank contents are driven out to the logical devices on the `dev_*` outputs. Chip and vendor identification bytes are global and read-only. While the port pair is closed, every read returns 0xFF. Software that probes the pair therefore sees "nothing here" and can try another pair.

Read data is registered. `rdata_o` takes the value of the accessed register on the clock edge that samples `rd_i`, and it holds that value until the next read.

Top module: `superio_cfg_port`

## Requirements
- R1: Configuration mode opens only after the unlock byte (default 0x87) is written to the index port on two consecutive index writes. Any other index write after the first unlock byte restarts the sequence.
- R2: While open, an index write of the lock byte (default 0xAA) closes configuration mode, and `cfg_open_o` falls on the next cycle.
- R3: While closed, reads of either port return 0xFF. Every read updates `rdata_o` one cycle after `rd_i` is sampled. After reset the port is closed and `rdata_o` is 0xFF.
- R4: Data-port writes while closed change no register and no device output.
- R5: While open, an index write other than the lock byte sets the current index, and an index-port read returns it. A data-port access reads or writes the register at the current index.
- R6: Index 0x07 holds the logical-device number, 8 bits, read back as written. It selects the bank reached at indexes 0x30, 0x60, 0x61 and 0x70.
- R7: Index 0x30 holds the device enable in bit 0. 0x01 enables and 0x00 disables. The other bits read 0, and bit d of `dev_en_o` follows device d.
- R8: Index 0x60 is the base address high byte and 0x61 the low byte. Device d's base appears on `dev_base_o[16*d +: 16]`.
- R9: Index 0x70 stores the low IRQ_W bits of the IRQ number, and the upper bits read 0. Device d's IRQ appears on `dev_irq_o[IRQ_W*d +: IRQ_W]`.
- R10: Indexes 0x20/0x21 return the chip ID high/low bytes, and 0x22/0x23 return the vendor ID high/low bytes. Writes to them have no effect.
- R11: With a device number of NUM_LDEV or more, bank indexes read 0x00 and writes to them have no effect. Any unimplemented index reads 0x00.
- R12: A bank write changes only the addressed register of the selected device. A read-modify-write of one bit leaves the other bits and the other devices unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| port_sel_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered host read data |
| cfg_open_o | output | 1 | Configuration mode is open |
| dev_en_o | output | NUM_LDEV | Enable bit per logical device |
| dev_base_o | output | 16*NUM_LDEV | I/O base address per logical device |
| dev_irq_o | output | IRQ_W*NUM_LDEV | IRQ number per logical device |

## Verification
The bench builds the block with NUM_LDEV = 3. Because that is not a power of two, device number 3 falls inside the select field yet beyond the last real bank, and the out-of-range path and the unused mux slot are both reached. IRQ_W = 4 makes the masking of the upper IRQ bits visible on readback. Non-default chip and vendor IDs show that the identification bytes come from the parameters. The random phase mixes unlock, lock, stray and register index writes, so broken unlock sequences and writes while half-unlocked occur often.

// File: rtl/superio_cfg_pkg.sv
package superio_cfg_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lk_state_e;

  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_CHIP_HI   = 8'h20;
  localparam logic [7:0] IDX_CHIP_LO   = 8'h21;
  localparam logic [7:0] IDX_VENDOR_HI = 8'h22;
  localparam logic [7:0] IDX_VENDOR_LO = 8'h23;
  localparam logic [7:0] IDX_EN        = 8'h30;
  localparam logic [7:0] IDX_BASE_HI   = 8'h60;
  localparam logic [7:0] IDX_BASE_LO   = 8'h61;
  localparam logic [7:0] IDX_IRQ       = 8'h70;
endpackage

// File: rtl/superio_cfg_lock.sv
module superio_cfg_lock
  import superio_cfg_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  lk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        LK_CLOSED: state_d = (wdata_i == UNLOCK_KEY) ? LK_HALF : LK_CLOSED;
        LK_HALF:   state_d = (wdata_i == UNLOCK_KEY) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   state_d = (wdata_i == LOCK_KEY) ? LK_CLOSED : LK_OPEN;
        default:   state_d = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_CLOSED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);

  AST_OPEN_NEEDS_TWO_KEYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_OPEN && $past(state_q) != LK_OPEN) |->
      ($past(state_q) == LK_HALF && $past(idx_wr_i) && $past(wdata_i) == UNLOCK_KEY)); // R1
  AST_LOCK_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == LOCK_KEY) |=> !open_o); // R2
endmodule

// File: rtl/superio_cfg_bank.sv
module superio_cfg_bank
  import superio_cfg_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       idx_i,
  input  logic [7:0]       wdata_i,
  output logic             en_o,
  output logic [15:0]      base_o,
  output logic [IRQ_W-1:0] irq_o,
  output logic [7:0]       rdata_o
);
  logic             en_q;
  logic [15:0]      base_q;
  logic [IRQ_W-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      irq_q  <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_EN:      en_q         <= wdata_i[0];
        IDX_BASE_HI: base_q[15:8] <= wdata_i;
        IDX_BASE_LO: base_q[7:0]  <= wdata_i;
        IDX_IRQ:     irq_q        <= wdata_i[IRQ_W-1:0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_EN:      rdata_o[0]         = en_q;
      IDX_BASE_HI: rdata_o            = base_q[15:8];
      IDX_BASE_LO: rdata_o            = base_q[7:0];
      IDX_IRQ:     rdata_o[IRQ_W-1:0] = irq_q;
      default:     ;
    endcase
  end

  assign en_o   = en_q;
  assign base_o = base_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/superio_cfg_port.sv
module superio_cfg_port
  import superio_cfg_pkg::*;
#(
  parameter int          NUM_LDEV   = 4,
  parameter int          IRQ_W      = 4,
  parameter logic [7:0]  UNLOCK_KEY = 8'h87,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA,
  parameter logic [15:0] CHIP_ID    = 16'h1234,
  parameter logic [15:0] VENDOR_ID  = 16'h5678
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic                      port_sel_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  output logic                      cfg_open_o,
  output logic [NUM_LDEV-1:0]       dev_en_o,
  output logic [16*NUM_LDEV-1:0]    dev_base_o,
  output logic [IRQ_W*NUM_LDEV-1:0] dev_irq_o
);
  localparam int         LDN_W   = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam int         LDN_CNT = 1 << LDN_W;
  localparam logic [7:0] LDN_LIM = 8'(NUM_LDEV);

  logic             open;
  logic             idx_wr, data_wr;
  logic [7:0]       idx_q, ldn_q, rd_val, rdata_q;
  logic             ldn_ok;
  logic [LDN_W-1:0] ldn_sel;
  logic [7:0]       bank_rdata [LDN_CNT];
  logic [NUM_LDEV-1:0] bank_wr;

  assign idx_wr  = wr_i && !port_sel_i;
  assign data_wr = wr_i && port_sel_i && open;
  assign ldn_ok  = ldn_q < LDN_LIM;
  assign ldn_sel = ldn_q[LDN_W-1:0];

  superio_cfg_lock #(
    .UNLOCK_KEY(UNLOCK_KEY),
    .LOCK_KEY  (LOCK_KEY)
  ) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_wr_i(idx_wr),
    .wdata_i (wdata_i),
    .open_o  (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_wr && open && wdata_i != LOCK_KEY) idx_q <= wdata_i;
      if (data_wr && idx_q == IDX_LDN)            ldn_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < LDN_CNT; g++) begin : g_bank
    if (g < NUM_LDEV) begin : g_real
      assign bank_wr[g] = data_wr && ldn_q == 8'(g);
      superio_cfg_bank #(.IRQ_W(IRQ_W)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (bank_wr[g]),
        .idx_i  (idx_q),
        .wdata_i(wdata_i),
        .en_o   (dev_en_o[g]),
        .base_o (dev_base_o[16*g +: 16]),
        .irq_o  (dev_irq_o[IRQ_W*g +: IRQ_W]),
        .rdata_o(bank_rdata[g])
      );
    end else begin : g_pad
      assign bank_rdata[g] = '0;
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    if (open) begin
      if (!port_sel_i) rd_val = idx_q;
      else begin
        unique case (idx_q)
          IDX_LDN:       rd_val = ldn_q;
          IDX_CHIP_HI:   rd_val = CHIP_ID[15:8];
          IDX_CHIP_LO:   rd_val = CHIP_ID[7:0];
          IDX_VENDOR_HI: rd_val = VENDOR_ID[15:8];
          IDX_VENDOR_LO: rd_val = VENDOR_ID[7:0];
          IDX_EN, IDX_BASE_HI, IDX_BASE_LO, IDX_IRQ:
                         rd_val = ldn_ok ? bank_rdata[ldn_sel] : 8'h00;
          default:       rd_val = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'hFF;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o    = rdata_q;
  assign cfg_open_o = open;

  AST_CLOSED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open_o && rd_i) |=> rdata_o == 8'hFF); // R3
  AST_CLOSED_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open_o && wr_i && port_sel_i) |=>
      ($stable(dev_en_o) && $stable(dev_base_o) && $stable(dev_irq_o))); // R4
  AST_OOR_LDN_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open_o && wr_i && port_sel_i && !ldn_ok) |=>
      ($stable(dev_en_o) && $stable(dev_base_o) && $stable(dev_irq_o))); // R11
  AST_ONE_BANK_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_wr)); // R12
endmodule

// File: tb/sim_superio_cfg_port.sv
`timescale 1ns/1ps
module sim_superio_cfg_port;
  localparam int          N    = 3;
  localparam int          IW   = 4;
  localparam logic [15:0] CHIP = 16'hA1B2;
  localparam logic [15:0] VEND = 16'hC3D4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, psel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cfg_open;
  logic [N-1:0] dev_en;
  logic [16*N-1:0] dev_base;
  logic [IW*N-1:0] dev_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_mode;                 // 0 closed, 1 half, 2 open
  logic [7:0] m_idx, m_ldn;
  logic m_en [N];
  logic [15:0] m_base [N];
  logic [IW-1:0] m_irq [N];

  always #2 clk = ~clk;

  superio_cfg_port #(.NUM_LDEV(N), .IRQ_W(IW), .CHIP_ID(CHIP), .VENDOR_ID(VEND)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .port_sel_i(psel),
    .wdata_i(wdata), .rdata_o(rdata), .cfg_open_o(cfg_open),
    .dev_en_o(dev_en), .dev_base_o(dev_base), .dev_irq_o(dev_irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic port);
    if (m_mode != 2) return 8'hFF;
    if (!port) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h22: return VEND[15:8];
      8'h23: return VEND[7:0];
      8'h30: return (m_ldn < N) ? {7'b0, m_en[m_ldn]} : 8'h00;
      8'h60: return (m_ldn < N) ? m_base[m_ldn][15:8] : 8'h00;
      8'h61: return (m_ldn < N) ? m_base[m_ldn][7:0] : 8'h00;
      8'h70: return (m_ldn < N) ? 8'(m_irq[m_ldn]) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(logic port);
    if (m_mode != 2) return "R3";
    if (!port) return "R5";
    case (m_idx)
      8'h07: return "R6";
      8'h20, 8'h21, 8'h22, 8'h23: return "R10";
      8'h30, 8'h60, 8'h61, 8'h70: return (m_ldn < N) ? "R12" : "R11";
      default: return "R11";
    endcase
  endfunction

  task automatic model_wr(logic port, logic [7:0] v);
    if (!port) begin
      case (m_mode)
        0: m_mode = (v == 8'h87) ? 1 : 0;
        1: m_mode = (v == 8'h87) ? 2 : 0;
        default: if (v == 8'hAA) m_mode = 0; else m_idx = v;
      endcase
    end else if (m_mode == 2) begin
      if (m_idx == 8'h07) m_ldn = v;
      else if (m_ldn < N) begin
        case (m_idx)
          8'h30: m_en[m_ldn] = v[0];
          8'h60: m_base[m_ldn][15:8] = v;
          8'h61: m_base[m_ldn][7:0] = v;
          8'h70: m_irq[m_ldn] = v[IW-1:0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic do_wr(logic port, logic [7:0] v);
    @(negedge clk);
    wr = 1'b1; psel = port; wdata = v;
    model_wr(port, v);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(logic port, output logic [7:0] v);
    @(negedge clk);
    rd = 1'b1; psel = port;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic rd_chk(logic port);
    logic [7:0] v;
    string r;
    r = req_of(port);
    do_rd(port, v);
    check(r, 32'(v), 32'(exp_read(port)));
  endtask

  task automatic out_chk(string req);
    check({req, " open"}, 32'(cfg_open), 32'(m_mode == 2));
    for (int d = 0; d < N; d++) begin
      check({req, " R7 en"}, 32'(dev_en[d]), 32'(m_en[d]));
      check({req, " R8 base"}, 32'(dev_base[16*d +: 16]), 32'(m_base[d]));
      check({req, " R9 irq"}, 32'(dev_irq[IW*d +: IW]), 32'(m_irq[d]));
    end
  endtask

  task automatic reg_w(logic [7:0] idx, logic [7:0] v);
    do_wr(1'b0, idx);
    do_wr(1'b1, v);
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_mode = 0; m_idx = 0; m_ldn = 0;
    for (int d = 0; d < N; d++) begin m_en[d] = 0; m_base[d] = 0; m_irq[d] = 0; end
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    check("R3 reset rdata", 32'(rdata), 32'hFF);
    out_chk("R3 reset");
    rd_chk(1'b0);
    rd_chk(1'b1);

    // R1 broken sequence, then proper unlock
    do_wr(1'b0, 8'h87);
    do_wr(1'b0, 8'h42);
    do_wr(1'b0, 8'h87);
    check("R1 broken seq", 32'(cfg_open), 32'h0);
    do_wr(1'b1, 8'h33);            // R4 data write while half-unlocked
    out_chk("R4");
    do_wr(1'b0, 8'h87);
    check("R1 open", 32'(cfg_open), 32'h1);

    // R10 ids, read-only
    reg_w(8'h20, 8'h55);
    do_rd(1'b1, v); check("R10 chip hi", 32'(v), 32'(CHIP[15:8]));
    do_wr(1'b0, 8'h23); do_rd(1'b1, v); check("R10 vendor lo", 32'(v), 32'(VEND[7:0]));
    do_rd(1'b0, v); check("R5 index read", 32'(v), 32'h23);

    // R6 / R8 / R7 / R9 on device 1
    reg_w(8'h07, 8'h01);
    reg_w(8'h60, 8'h3F);
    reg_w(8'h61, 8'h80);
    reg_w(8'h30, 8'hFF);
    reg_w(8'h70, 8'hAB);
    do_rd(1'b1, v); check("R9 irq mask", 32'(v), 32'h0B);
    do_wr(1'b0, 8'h30); do_rd(1'b1, v); check("R7 enable read", 32'(v), 32'h01);
    check("R8 base out", 32'(dev_base[16 +: 16]), 32'h3F80);
    out_chk("R8");

    // R12 read-modify-write of one bit
    do_wr(1'b0, 8'h61);
    do_rd(1'b1, v);
    do_wr(1'b1, v | 8'h04);
    do_rd(1'b1, v); check("R12 rmw", 32'(v), 32'h84);
    check("R12 dev0 untouched", 32'(dev_base[15:0]), 32'h0000);
    reg_w(8'h30, 8'h00);
    check("R7 disable", 32'(dev_en[1]), 32'h0);

    // R11 out-of-range device and unimplemented index
    reg_w(8'h07, 8'h03);
    do_rd(1'b1, v); check("R6 ldn readback", 32'(v), 32'h03);
    reg_w(8'h60, 8'hEE);
    do_rd(1'b1, v); check("R11 oor read", 32'(v), 32'h00);
    out_chk("R11");
    do_wr(1'b0, 8'h55); do_rd(1'b1, v); check("R11 unimpl", 32'(v), 32'h00);

    // R2 lock, R4 write while closed
    do_wr(1'b0, 8'hAA);
    check("R2 closed", 32'(cfg_open), 32'h0);
    rd_chk(1'b0);
    do_wr(1'b1, 8'h99);
    out_chk("R4 closed");
    do_wr(1'b0, 8'h87); do_wr(1'b0, 8'h87);
    rd_chk(1'b0);
    check("R2 index kept", 32'(rdata), 32'h55);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] val;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 11))
        0, 1: val = 8'h87;
        2: val = 8'hAA;
        3: val = 8'h07;
        4: val = 8'h30;
        5: val = 8'h60;
        6: val = 8'h61;
        7: val = 8'h70;
        8: val = 8'(8'h20 + $urandom_range(0, 3));
        9: val = 8'(m_mode == 2 && m_idx == 8'h07 ? $urandom_range(0, N + 1) : $urandom_range(0, 255));
        default: val = 8'($urandom_range(0, 255));
      endcase
      if (op < 4)      do_wr(1'b0, val);
      else if (op < 7) do_wr(1'b1, val);
      else             rd_chk(op[0]);
      if (i % 50 == 0) out_chk("R12 rand");
    end
    out_chk("R12 final");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule